// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block sits between a per-bank request holder and a DRAM command bus. In every clock cycle it selects at most one command for the channel: activate a row, precharge a bank, issue a read column burst, issue a write column burst, or do nothing. Each bank keeps one pending request, which carries a row, a size in bytes, a read/write flag and a tag. Each bank also tracks its open row and whether it is active. Per-bank countdown timers enforce activate-to-column, activate-to-precharge, activate-to-activate and precharge-to-activate spacing. Shared timers enforce column-to-column spacing, activate-to-activate spacing across banks, and the read/write bus turnarounds.

Banks are examined starting from a rotating priority index, and the first bank with a legal command wins. Row commands move the priority index past the bank that was served; column commands leave it alone. Every column command is one burst pushed into a downstream data-return queue. That queue can hold off column commands with its full flag, and it is told which minimum latency to apply (CAS latency for reads, write latency for writes) according to the current bus direction.

Requests enter through a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on whether the bank named by `req_bank` already holds a request, so a request aimed at a busy bank waits without blocking anything inside the block. The return queue applies back-pressure through `rq_full`: while it is high no column command issues, but activates and precharges carry on. The timing values are static configuration inputs, held stable outside reset.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset no command issues (`cmd_valid`=0, `cmd_code`=0), `nop_count` is 0, every bank is idle and empty, the bus direction is read, and the priority index is 0. Command codes are NOP=0, ACT=1, PRE=2, RD=3 and WR=4.
- R2: `req_ready` is high exactly when the bank addressed by `req_bank` holds no request. An accepted request is visible to the scheduler from the next cycle on, and the bank stays busy until its final column command.
- R3: An idle bank with a request is activated once tRP has passed since that bank's last precharge, tRC since its last activate, and tRRD since any activate. A read to the opened row issues no earlier than tRCD cycles after the activate.
- R4: A write column command needs the bank active on the request's row and at least max(tRCD − (WL + 1), 0) cycles since that bank's activate.
- R5: A bank that is active on a row other than its request's row is precharged once tRAS cycles have passed since its activate. It then becomes idle.
- R6: Two column commands, on any banks, are at least tCCD cycles apart.
- R7: Two activates, on any banks, are at least tRRD cycles apart.
- R8: A write column command issues at least max(CL + BL/2 + 2 − WL, 0) cycles after the last read column command.
- R9: A read column command issues at least tWTR cycles after the last write column command.
- R10: While `rq_full` is high no read or write column command issues. Activates and precharges are not held back by it.
- R11: At most one command issues per cycle. Banks are scanned in the order (prio + i) mod N, and the first legal one wins. An activate or precharge on bank b sets prio to (b + 1) mod N; column commands leave prio unchanged.
- R12: Each column command moves BL × bus bytes × devices bytes (16 with the default parameters). `cmd_last` is high on the column command that brings the moved count to at least the request size, and that command frees the bank for a new request from the next cycle.
- R13: `rq_wr_mode` shows the bus direction: 0 for read and 1 for write. It changes in the same cycle as the column command that switches direction and otherwise holds. `rq_min_lat` equals WL when `rq_wr_mode` is 1 and CL when it is 0.
- R14: `nop_count` increases by one after every cycle in which no command issues, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tccd | input | TMR_W | Column-to-column spacing |
| cfg_trrd | input | TMR_W | Activate-to-activate spacing across banks |
| cfg_trcd | input | TMR_W | Activate-to-read spacing |
| cfg_tras | input | TMR_W | Activate-to-precharge spacing |
| cfg_trp | input | TMR_W | Precharge-to-activate spacing |
| cfg_trc | input | TMR_W | Activate-to-activate spacing within a bank |
| cfg_cl | input | TMR_W | CAS latency |
| cfg_wl | input | TMR_W | Write latency |
| cfg_twtr | input | TMR_W | Write-to-read spacing |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Addressed bank can take the request |
| req_bank | input | IDX_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_size | input | SIZE_W | Request size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request handle |
| rq_full | input | 1 | Return queue cannot take a burst |
| rq_wr_mode | output | 1 | Current bus direction, 1 = write |
| rq_min_lat | output | TMR_W | Minimum return latency for the queue |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | IDX_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the served request |
| cmd_tag | output | TAG_W | Handle of the served request |
| cmd_last | output | 1 | Final column burst of the request |
| nop_count | output | CNT_W | Count of idle command cycles |

## Verification
The bench uses the default parameters: four banks, 16-byte bursts and 8-bit sizes, so requests of one to four bursts and rotation over a full wrap of the priority index are within reach. It first runs with CL=5 and WL=2, which gives a positive turnaround of 7 and a write activate delay of 1. After a reset it runs again with CL=2 and WL=7, where both derived delays go negative and have to clamp to zero, so a write may follow its activate in the very next cycle. Directed phases cover row hits, row conflicts, multi-burst requests, direction switches and a window with the return queue full. A long randomized phase then mixes all of these with random back-pressure.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dsch_cmd_e;
endpackage

// File: rtl/dsch_countdown.sv
module dsch_countdown #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  // a load of T keeps the counter nonzero for T-1 following cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= (val == '0) ? '0 : val - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dsch_bank.sv
module dsch_bank
  import dsch_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int SIZE_W = 8,
  parameter int TAG_W  = 4,
  parameter int TMR_W  = 6,
  parameter int BEAT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              ld_wr,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              grant,
  input  logic              ccd_zero,
  input  logic              rrd_zero,
  input  logic              rtw_zero,
  input  logic              wtr_zero,
  input  logic              rq_full,
  input  logic [TMR_W-1:0]  t_rcd,
  input  logic [TMR_W-1:0]  t_rcd_wr,
  input  logic [TMR_W-1:0]  t_ras,
  input  logic [TMR_W-1:0]  t_rc,
  input  logic [TMR_W-1:0]  t_rp,
  output logic              busy,
  output dsch_cmd_e         cand,
  output logic [ROW_W-1:0]  row,
  output logic [TAG_W-1:0]  tag,
  output logic              fin
);
  localparam int NT    = 5;
  localparam int SUM_W = SIZE_W + 2;
  localparam int K_RCD = 0, K_RCDW = 1, K_RAS = 2, K_RC = 3, K_RP = 4;

  logic              pend_q, wr_q, open_q;
  logic [ROW_W-1:0]  row_q, orow_q;
  logic [SIZE_W-1:0] size_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SIZE_W:0]   sent_q;
  logic [SUM_W-1:0]  sent_sum;
  logic [NT-1:0]     t_load, t_zero;
  logic [TMR_W-1:0]  t_val [NT];
  logic              hit, do_act, do_pre, do_col;

  assign do_act = grant && (cand == CMD_ACT);
  assign do_pre = grant && (cand == CMD_PRE);
  assign do_col = grant && ((cand == CMD_RD) || (cand == CMD_WR));

  assign t_val[K_RCD]  = t_rcd;
  assign t_val[K_RCDW] = t_rcd_wr;
  assign t_val[K_RAS]  = t_ras;
  assign t_val[K_RC]   = t_rc;
  assign t_val[K_RP]   = t_rp;
  assign t_load = {do_pre, do_act, do_act, do_act, do_act};

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    dsch_countdown #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load[k]), .val(t_val[k]), .zero(t_zero[k])
    );
  end

  assign hit = open_q && (orow_q == row_q);

  always_comb begin
    cand = CMD_NOP;
    if (pend_q) begin
      if (hit && !wr_q && t_zero[K_RCD] && ccd_zero && wtr_zero && !rq_full)
        cand = CMD_RD;
      else if (hit && wr_q && t_zero[K_RCDW] && ccd_zero && rtw_zero && !rq_full)
        cand = CMD_WR;
      else if (!open_q && rrd_zero && t_zero[K_RP] && t_zero[K_RC])
        cand = CMD_ACT;
      else if (open_q && !hit && t_zero[K_RAS])
        cand = CMD_PRE;
    end
  end

  assign sent_sum = SUM_W'(sent_q) + SUM_W'(BEAT);
  assign fin      = ((cand == CMD_RD) || (cand == CMD_WR)) && (sent_sum >= SUM_W'(size_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      open_q <= 1'b0;
      row_q  <= '0;
      orow_q <= '0;
      size_q <= '0;
      tag_q  <= '0;
      sent_q <= '0;
    end else begin
      if (ld) begin
        pend_q <= 1'b1;
        row_q  <= ld_row;
        size_q <= ld_size;
        wr_q   <= ld_wr;
        tag_q  <= ld_tag;
        sent_q <= '0;
      end
      if (do_col) begin
        if (fin) pend_q <= 1'b0;
        sent_q <= fin ? '0 : sent_sum[SIZE_W:0];
      end
      if (do_act) begin
        open_q <= 1'b1;
        orow_q <= row_q;
      end
      if (do_pre) open_q <= 1'b0;
    end
  end

  assign busy = pend_q;
  assign row  = row_q;
  assign tag  = tag_q;
endmodule

// File: rtl/dsch_pick.sv
module dsch_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     want,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0] pos;

  // walk from the far end so the position nearest to start is kept last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      pos = {1'b0, start} + (IDX_W + 1)'(i);
      if (pos >= (IDX_W + 1)'(N)) pos = pos - (IDX_W + 1)'(N);
      if (want[pos[IDX_W-1:0]]) begin
        found = 1'b1;
        idx   = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
  import dsch_pkg::*;
#(
  parameter int N_BANKS   = 4,
  parameter int ROW_W     = 12,
  parameter int SIZE_W    = 8,
  parameter int TAG_W     = 4,
  parameter int TMR_W     = 6,
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4,
  parameter int BUS_BYTES = 4,
  parameter int DEVS      = 1,
  localparam int IDX_W    = $clog2(N_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  cfg_tccd,
  input  logic [TMR_W-1:0]  cfg_trrd,
  input  logic [TMR_W-1:0]  cfg_trcd,
  input  logic [TMR_W-1:0]  cfg_tras,
  input  logic [TMR_W-1:0]  cfg_trp,
  input  logic [TMR_W-1:0]  cfg_trc,
  input  logic [TMR_W-1:0]  cfg_cl,
  input  logic [TMR_W-1:0]  cfg_wl,
  input  logic [TMR_W-1:0]  cfg_twtr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              rq_full,
  output logic              rq_wr_mode,
  output logic [TMR_W-1:0]  rq_min_lat,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [IDX_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic              cmd_last,
  output logic [CNT_W-1:0]  nop_count
);
  localparam int BEAT   = BURST_LEN * BUS_BYTES * DEVS;
  localparam int TURN_K = BURST_LEN / 2 + 2;
  localparam int EXT_W  = TMR_W + 2;

  logic [N_BANKS-1:0] busy, want, fin, grant, ld;
  dsch_cmd_e          cand [N_BANKS];
  logic [ROW_W-1:0]   brow [N_BANKS];
  logic [TAG_W-1:0]   btag [N_BANKS];
  logic               found;
  logic [IDX_W-1:0]   win, prio_q;
  dsch_cmd_e          win_cmd;
  logic               dir_q;
  logic [CNT_W-1:0]   nop_q;
  logic               ccd_z, rrd_z, rtw_z, wtr_z;
  logic [TMR_W-1:0]   t_rcd_wr, t_turn;
  logic [EXT_W-1:0]   turn_sum, turn_dif;

  // derived delays, clamped at zero (and at the counter maximum)
  assign t_rcd_wr = (cfg_trcd > cfg_wl) ? cfg_trcd - cfg_wl - 1'b1 : '0;
  assign turn_sum = EXT_W'(cfg_cl) + EXT_W'(TURN_K);
  assign turn_dif = turn_sum - EXT_W'(cfg_wl);
  assign t_turn   = (turn_sum <= EXT_W'(cfg_wl)) ? '0 :
                    (|turn_dif[EXT_W-1:TMR_W]) ? '1 : turn_dif[TMR_W-1:0];

  assign req_ready = (int'(req_bank) < N_BANKS) ? !busy[req_bank] : 1'b0;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign ld[b]    = req_valid && req_ready && (int'(req_bank) == b);
    assign grant[b] = found && (int'(win) == b);
    assign want[b]  = (cand[b] != CMD_NOP);
    dsch_bank #(
      .ROW_W(ROW_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .TMR_W(TMR_W), .BEAT(BEAT)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ld(ld[b]), .ld_row(req_row), .ld_size(req_size), .ld_wr(req_write), .ld_tag(req_tag),
      .grant(grant[b]),
      .ccd_zero(ccd_z), .rrd_zero(rrd_z), .rtw_zero(rtw_z), .wtr_zero(wtr_z), .rq_full(rq_full),
      .t_rcd(cfg_trcd), .t_rcd_wr(t_rcd_wr), .t_ras(cfg_tras), .t_rc(cfg_trc), .t_rp(cfg_trp),
      .busy(busy[b]), .cand(cand[b]), .row(brow[b]), .tag(btag[b]), .fin(fin[b])
    );
  end

  dsch_pick #(.N(N_BANKS), .IDX_W(IDX_W)) u_pick (
    .want(want), .start(prio_q), .found(found), .idx(win)
  );

  assign win_cmd = found ? cand[win] : CMD_NOP;

  // channel-wide spacing timers
  dsch_countdown #(.W(TMR_W)) u_ccd (
    .clk(clk), .rst_n(rst_n), .load((win_cmd == CMD_RD) || (win_cmd == CMD_WR)),
    .val(cfg_tccd), .zero(ccd_z));
  dsch_countdown #(.W(TMR_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(win_cmd == CMD_ACT), .val(cfg_trrd), .zero(rrd_z));
  dsch_countdown #(.W(TMR_W)) u_rtw (
    .clk(clk), .rst_n(rst_n), .load(win_cmd == CMD_RD), .val(t_turn), .zero(rtw_z));
  dsch_countdown #(.W(TMR_W)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(win_cmd == CMD_WR), .val(cfg_twtr), .zero(wtr_z));

  always_comb begin
    rq_wr_mode = dir_q;
    if (win_cmd == CMD_RD) rq_wr_mode = 1'b0;
    if (win_cmd == CMD_WR) rq_wr_mode = 1'b1;
  end
  assign rq_min_lat = rq_wr_mode ? cfg_wl : cfg_cl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      dir_q  <= 1'b0;
      nop_q  <= '0;
    end else begin
      dir_q <= rq_wr_mode;
      if (!found) nop_q <= nop_q + 1'b1;
      if ((win_cmd == CMD_ACT) || (win_cmd == CMD_PRE))
        prio_q <= (int'(win) == N_BANKS - 1) ? '0 : win + 1'b1;
    end
  end

  assign cmd_valid = found;
  assign cmd_code  = win_cmd;
  assign cmd_bank  = win;
  assign cmd_row   = brow[win];
  assign cmd_tag   = btag[win];
  assign cmd_last  = found && fin[win];
  assign nop_count = nop_q;
endmodule

// File: rtl/dsch_checker.sv
module dsch_checker
  import dsch_pkg::*;
#(
  parameter int N_BANKS = 4,
  parameter int TMR_W   = 6,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_code,
  input logic             rq_full,
  input logic             rq_wr_mode,
  input logic [CNT_W-1:0] nop_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_bank,
  input logic [TMR_W-1:0] cfg_tccd,
  input logic [TMR_W-1:0] cfg_trrd,
  input logic [TMR_W-1:0] cfg_twtr
);
  logic        is_col, seen_col, seen_wr, seen_act;
  logic [15:0] since_col, since_wr, since_act;

  assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

  // cycles elapsed since the last event of each kind, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_col <= 1'b0; seen_wr <= 1'b0; seen_act <= 1'b0;
      since_col <= '0;  since_wr <= '0;  since_act <= '0;
    end else begin
      if (is_col) begin seen_col <= 1'b1; since_col <= 16'd1; end
      else if (since_col != '1) since_col <= since_col + 1'b1;
      if (cmd_code == CMD_WR) begin seen_wr <= 1'b1; since_wr <= 16'd1; end
      else if (since_wr != '1) since_wr <= since_wr + 1'b1;
      if (cmd_code == CMD_ACT) begin seen_act <= 1'b1; since_act <= 16'd1; end
      else if (since_act != '1) since_act <= since_act + 1'b1;
    end
  end

  p_col_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && seen_col) |-> (since_col >= 16'(cfg_tccd)));

  p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_ACT) && seen_act) |-> (since_act >= 16'(cfg_trrd)));

  p_wr_to_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_RD) && seen_wr) |-> (since_wr >= 16'(cfg_twtr)));

  p_full_holds_col_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_full |-> !is_col);

  p_taken_bank_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready || (req_bank != $past(req_bank))));

  p_dir_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP) |-> (rq_wr_mode == $past(rq_wr_mode)));

  p_nop_tally_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP) |=> (nop_count == CNT_W'($past(nop_count) + 1'b1)));
endmodule

bind dram_cmd_sched dsch_checker #(
  .N_BANKS(N_BANKS), .TMR_W(TMR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .rq_full(rq_full),
  .rq_wr_mode(rq_wr_mode), .nop_count(nop_count), .req_valid(req_valid),
  .req_ready(req_ready), .req_bank(req_bank), .cfg_tccd(cfg_tccd),
  .cfg_trrd(cfg_trrd), .cfg_twtr(cfg_twtr)
);

// File: tb/dram_cmd_sched_tb.sv
module dram_cmd_sched_tb;
  localparam int NB = 4, ROW_W = 12, SIZE_W = 8, TAG_W = 4, TMR_W = 6, CNT_W = 16;
  localparam int BL = 4, BEAT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [TMR_W-1:0] cfg_tccd, cfg_trrd, cfg_trcd, cfg_tras, cfg_trp, cfg_trc, cfg_cl, cfg_wl, cfg_twtr;
  logic req_valid = 1'b0, req_write = 1'b0, rq_full = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, rq_wr_mode, cmd_valid, cmd_last;
  logic [TMR_W-1:0] rq_min_lat;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [TAG_W-1:0] cmd_tag;
  logic [CNT_W-1:0] nop_count;

  dram_cmd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tccd(cfg_tccd), .cfg_trrd(cfg_trrd), .cfg_trcd(cfg_trcd),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_cl(cfg_cl), .cfg_wl(cfg_wl),
    .cfg_twtr(cfg_twtr), .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_size(req_size), .req_write(req_write), .req_tag(req_tag),
    .rq_full(rq_full), .rq_wr_mode(rq_wr_mode), .rq_min_lat(rq_min_lat), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_tag(cmd_tag),
    .cmd_last(cmd_last), .nop_count(nop_count)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // timing configuration as the bench sees it
  int c_ccd, c_rrd, c_rcd, c_ras, c_rp, c_rc, c_cl, c_wl, c_wtr, d_wrcd, d_turn;

  // behavioural reference: event timestamps rather than countdowns
  int cyc, m_prio, m_mode, m_nops, t_col, t_rd, t_wr, t_actg;
  int m_has[NB], m_wr[NB], m_row[NB], m_size[NB], m_tag[NB], m_sent[NB];
  int m_open[NB], m_orow[NB], m_tact[NB], m_tpre[NB];

  int q_bank[$], q_row[$], q_size[$], q_wr[$], q_tag[$];
  int full_until = 0;
  bit rand_full = 0;

  task automatic check(bit ok, string rq, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", rq, what, cyc, got, exp);
    end
  endtask

  task automatic push_req(int b, int r, int s, int w, int t);
    q_bank.push_back(b); q_row.push_back(r); q_size.push_back(s);
    q_wr.push_back(w); q_tag.push_back(t);
  endtask

  function automatic int cand_of(int b);
    bit hit;
    if (m_has[b] == 0) return 0;
    hit = (m_open[b] != 0) && (m_orow[b] == m_row[b]);
    if (hit && m_wr[b] == 0 && cyc >= m_tact[b] + c_rcd && cyc >= t_col + c_ccd &&
        cyc >= t_wr + c_wtr && !rq_full) return 3;
    if (hit && m_wr[b] != 0 && cyc >= m_tact[b] + d_wrcd && cyc >= t_col + c_ccd &&
        cyc >= t_rd + d_turn && !rq_full) return 4;
    if (m_open[b] == 0 && cyc >= t_actg + c_rrd && cyc >= m_tpre[b] + c_rp &&
        cyc >= m_tact[b] + c_rc) return 1;
    if (m_open[b] != 0 && !hit && cyc >= m_tact[b] + c_ras) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    cyc = 0; m_prio = 0; m_mode = 0; m_nops = 0;
    t_col = -1000; t_rd = -1000; t_wr = -1000; t_actg = -1000;
    for (int b = 0; b < NB; b++) begin
      m_has[b] = 0; m_wr[b] = 0; m_row[b] = 0; m_size[b] = 0; m_tag[b] = 0; m_sent[b] = 0;
      m_open[b] = 0; m_orow[b] = 0; m_tact[b] = -1000; m_tpre[b] = -1000;
    end
  endtask

  // compare this cycle's outputs with the reference, then advance the reference
  task automatic eval_cycle(string tg);
    int eb, ec, el, em;
    bit er;
    eb = 0; ec = 0;
    for (int i = 0; i < NB; i++) begin
      int b;
      int c;
      b = (m_prio + i) % NB;
      c = cand_of(b);
      if (c != 0) begin eb = b; ec = c; break; end
    end
    el = ((ec == 3 || ec == 4) && m_sent[eb] + BEAT >= m_size[eb]) ? 1 : 0;
    em = (ec == 3) ? 0 : (ec == 4) ? 1 : m_mode;
    er = req_valid && (m_has[int'(req_bank)] == 0);

    check(int'(cmd_code) == ec, tg, "cmd_code", int'(cmd_code), ec);
    check(cmd_valid == (ec != 0), tg, "cmd_valid", int'(cmd_valid), int'(ec != 0));
    if (ec != 0) begin
      check(int'(cmd_bank) == eb, tg, "cmd_bank", int'(cmd_bank), eb);
      check(int'(cmd_row) == m_row[eb], tg, "cmd_row", int'(cmd_row), m_row[eb]);
      check(int'(cmd_tag) == m_tag[eb], tg, "cmd_tag", int'(cmd_tag), m_tag[eb]);
      check(int'(cmd_last) == el, "R12", "cmd_last", int'(cmd_last), el);
    end
    check(int'(rq_wr_mode) == em, "R13", "rq_wr_mode", int'(rq_wr_mode), em);
    check(int'(rq_min_lat) == (em != 0 ? c_wl : c_cl), "R13", "rq_min_lat",
          int'(rq_min_lat), em != 0 ? c_wl : c_cl);
    check(int'(nop_count) == m_nops, "R14", "nop_count", int'(nop_count), m_nops);
    if (req_valid) check(req_ready == er, "R2", "req_ready", int'(req_ready), int'(er));

    case (ec)
      1: begin m_open[eb] = 1; m_orow[eb] = m_row[eb]; m_tact[eb] = cyc; t_actg = cyc;
               m_prio = (eb + 1) % NB; end
      2: begin m_open[eb] = 0; m_tpre[eb] = cyc; m_prio = (eb + 1) % NB; end
      3, 4: begin
        t_col = cyc;
        if (ec == 3) t_rd = cyc; else t_wr = cyc;
        m_sent[eb] += BEAT;
        if (el != 0) begin m_has[eb] = 0; m_sent[eb] = 0; end
      end
      default: m_nops = (m_nops + 1) % 65536;
    endcase
    m_mode = em;
    if (er) begin
      int b;
      b = int'(req_bank);
      m_has[b] = 1; m_row[b] = int'(req_row); m_size[b] = int'(req_size);
      m_wr[b] = int'(req_write); m_tag[b] = int'(req_tag); m_sent[b] = 0;
      void'(q_bank.pop_front()); void'(q_row.pop_front()); void'(q_size.pop_front());
      void'(q_wr.pop_front()); void'(q_tag.pop_front());
    end
    cyc++;
  endtask

  task automatic step(string tg);
    @(posedge clk); #1;
    if (q_bank.size() > 0) begin
      req_valid = 1'b1;
      req_bank  = 2'(q_bank[0]);
      req_row   = ROW_W'(q_row[0]);
      req_size  = SIZE_W'(q_size[0]);
      req_write = q_wr[0] != 0;
      req_tag   = TAG_W'(q_tag[0]);
    end else begin
      req_valid = 1'b0;
    end
    rq_full = (cyc < full_until) || (rand_full && ($urandom % 4 == 0));
    @(negedge clk);
    eval_cycle(tg);
  endtask

  function automatic bit work_left();
    if (q_bank.size() > 0) return 1;
    for (int b = 0; b < NB; b++) if (m_has[b] != 0) return 1;
    return 0;
  endfunction

  task automatic run_phase(string tg, int maxc);
    int n;
    n = 0;
    step(tg);
    while (work_left() && n < maxc) begin step(tg); n++; end
    check(!work_left(), tg, "phase drained", int'(work_left()), 0);
    step(tg); step(tg);
  endtask

  task automatic do_reset(int ccd, int rrd, int rcd, int ras, int rp, int rc, int cl, int wl, int wtr);
    rst_n = 1'b0; req_valid = 1'b0; rq_full = 1'b0; full_until = 0; rand_full = 0;
    c_ccd = ccd; c_rrd = rrd; c_rcd = rcd; c_ras = ras; c_rp = rp; c_rc = rc;
    c_cl = cl; c_wl = wl; c_wtr = wtr;
    d_wrcd = (rcd - (wl + 1) > 0) ? rcd - (wl + 1) : 0;
    d_turn = (cl + BL / 2 + 2 - wl > 0) ? cl + BL / 2 + 2 - wl : 0;
    cfg_tccd = TMR_W'(ccd); cfg_trrd = TMR_W'(rrd); cfg_trcd = TMR_W'(rcd);
    cfg_tras = TMR_W'(ras); cfg_trp = TMR_W'(rp); cfg_trc = TMR_W'(rc);
    cfg_cl = TMR_W'(cl); cfg_wl = TMR_W'(wl); cfg_twtr = TMR_W'(wtr);
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state straight after reset
    check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    check(nop_count == '0, "R1", "nop_count after reset", int'(nop_count), 0);
    check(rq_wr_mode == 1'b0, "R1", "direction after reset", int'(rq_wr_mode), 0);
    check(req_ready == 1'b1, "R1", "bank empty after reset", int'(req_ready), 1);
    eval_cycle("R1");
  endtask

  initial begin
    do_reset(2, 3, 4, 6, 3, 9, 5, 2, 3);
    push_req(0, 5, 16, 0, 1);                                  run_phase("R3", 200);
    push_req(1, 7, 32, 1, 2);                                  run_phase("R4", 200);
    push_req(0, 9, 16, 0, 3);                                  run_phase("R5", 200);
    push_req(2, 1, 16, 0, 4); push_req(3, 2, 16, 0, 5);
    push_req(1, 8, 16, 0, 6);                                  run_phase("R7", 200);
    push_req(2, 1, 64, 0, 7);                                  run_phase("R6", 200);
    push_req(3, 2, 16, 0, 8); push_req(2, 1, 16, 1, 9);        run_phase("R8", 200);
    push_req(2, 1, 16, 1, 10); push_req(3, 2, 16, 0, 11);      run_phase("R9", 200);
    full_until = cyc + 12;
    push_req(0, 9, 32, 0, 12); push_req(1, 30, 16, 0, 13);     run_phase("R10", 200);
    push_req(0, 20, 16, 0, 1); push_req(1, 21, 16, 0, 2);
    push_req(2, 22, 16, 0, 3); push_req(3, 23, 16, 0, 4);      run_phase("R11", 300);

    do_reset(1, 2, 4, 5, 2, 7, 2, 7, 2);
    push_req(0, 3, 16, 1, 5); push_req(0, 3, 32, 0, 6);
    push_req(0, 3, 16, 1, 7); push_req(1, 4, 16, 1, 8);        run_phase("R13", 300);
    push_req(0, 6, 48, 0, 9); push_req(0, 6, 16, 1, 10);       run_phase("R12", 300);

    rand_full = 1;
    for (int n = 0; n < 200; n++)
      push_req($urandom % NB, $urandom % 4, 16 * (1 + $urandom % 4), $urandom % 2, n % 16);
    run_phase("R11", 20000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d: got 0 expected 1", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule